// File: doc/BRIEF.md
# Smart Card Receive Convention Detector

This block sits behind the bit-level character receiver of an ISO 7816 smart card interface. Each raw character the receiver strobes in is held in a four-entry receive buffer. The head of the buffer is presented as a data byte decoded under the active coding convention. Under direct convention the character passes through unchanged. Under inverse convention every bit is complemented and the bit order is reversed.

The convention comes from one of two sources. It can be written by hand through a two-bit field, or the block can decide it on its own. With automatic detection armed before the answer-to-reset, the first character accepted after arming is stored and classified. It selects direct convention when it is 0x3B and inverse convention when it is 0x03, which is the raw pattern that decodes to 0x3F under inverse convention. Any other value raises a sticky detection-error flag. A programmable trigger level drives a data-available flag. Both flags have masked interrupt requests. Dropping the engine enable returns the block to idle.

Top module: `sc_conv_detect`

## Requirements
- R1: With autoEn low, a convWr pulse loads convSel into the convention when convSel is 00 (direct) or 11 (inverse). The reserved codes 01 and 10 are ignored and leave the convention unchanged. The stored characters are re-decoded under the new convention.
- R2: While autoEn is high, convWr pulses have no effect on convCur.
- R3: When armed, a first accepted raw character of 0x3B sets convCur to 00. That character is stored and delivered as 0x3B.
- R4: When armed, a first accepted raw character of 0x03 sets convCur to 11. The stored character reads out as 0x3F. Later characters are delivered as outByte[i] = ~raw[7-i].
- R5: When armed, any other first character sets acErr, leaves convCur unchanged and is still stored. acErrIrq equals acErr only while acErrIntEn is high.
- R6: Only the first accepted character after arming is classified. Later characters change neither convCur nor acErr. Arming happens whenever enable and autoEn are both high after either one was low.
- R7: rdaFlag is high while bufCount is at least the trigger level. trigSel 00 gives a level of 1, 01 gives 2, 10 gives 3, and the reserved 11 gives 1. rdaIrq is rdaFlag masked by rdaIntEn.
- R8: The buffer holds 4 characters in arrival order, and popReq removes the head. A character accepted while the buffer is full, with no pop in that cycle, is dropped and sets the sticky ovfFlag.
- R9: A push and a pop in the same cycle on a full buffer both take effect. bufCount stays at 4 and ovfFlag stays low.
- R10: With autoEn low, rxOff high stops new characters from being accepted. With autoEn high, rxOff is ignored.
- R11: enable low empties the buffer, clears acErr and ovfFlag, ignores rawValid and popReq, and re-arms detection. The convention is kept.
- R12: After reset, convCur is 00, the buffer is empty, and outValid, rdaFlag, acErr, ovfFlag and both interrupt requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Engine enable; low forces idle |
| rxOff | input | 1 | Receive disable (ignored while autoEn is high) |
| autoEn | input | 1 | Automatic convention detection enable |
| convWr | input | 1 | Write strobe for the manual convention field |
| convSel | input | 2 | Manual convention value: 00 direct, 11 inverse |
| trigSel | input | 2 | Data-available trigger level select |
| rdaIntEn | input | 1 | Data-available interrupt enable |
| acErrIntEn | input | 1 | Detection-error interrupt enable |
| rawValid | input | 1 | Raw character strobe from the bit receiver |
| rawByte | input | 8 | Raw character |
| popReq | input | 1 | Remove the buffer head |
| outByte | output | 8 | Decoded head of the buffer |
| outValid | output | 1 | Buffer not empty |
| bufCount | output | 3 | Number of buffered characters |
| convCur | output | 2 | Active convention |
| rdaFlag | output | 1 | Buffer count at or above the trigger level |
| rdaIrq | output | 1 | Data-available interrupt request |
| acErr | output | 1 | Detection error, sticky |
| acErrIrq | output | 1 | Detection-error interrupt request |
| ovfFlag | output | 1 | Buffer overflow, sticky |

## Verification
On a full buffer, a character store and a head removal can land in the same cycle. A mistaken full test would then drop the character and raise the overflow flag. The bench fills the buffer, raises rawValid and popReq together for one edge, and then requires the count to stay at 4, the overflow flag to stay low and the second-oldest character to appear at the head. The character classification and its storage also share one edge, so the stored start character is checked to read back already decoded under the convention it selected.

// File: rtl/sc_conv_pkg.sv
package sc_conv_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [1:0] {
    CONV_DIRECT  = 2'b00,
    CONV_RSV_A   = 2'b01,
    CONV_RSV_B   = 2'b10,
    CONV_INVERSE = 2'b11
  } conv_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic flush;
  } bufCtl_t;

  // inverse convention: complement and mirror the character
  function automatic logic [CHAR_W-1:0] decodeChar(input logic [CHAR_W-1:0] raw,
                                                   input logic inv);
    logic [CHAR_W-1:0] res;
    for (int i = 0; i < CHAR_W; i++) begin
      res[i] = inv ? ~raw[CHAR_W-1-i] : raw[i];
    end
    return res;
  endfunction

endpackage

// File: rtl/sc_conv_dp.sv
module sc_conv_dp
  import sc_conv_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufCtl_t           ctl,
  input  logic [CHAR_W-1:0] pushData,
  input  logic              invert,
  output logic [CHAR_W-1:0] headByte,
  output logic [CNT_W-1:0]  count
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [CHAR_W-1:0] store [DEPTH];
  logic [PTR_W-1:0]  rdPtr, wrPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else if (ctl.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (ctl.push) wrPtr <= nextPtr(wrPtr);
      if (ctl.pop)  rdPtr <= nextPtr(rdPtr);
      case ({ctl.push, ctl.pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // raw characters are stored; decoding happens at the read side
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        store[g] <= '0;
      end else if (ctl.push && !ctl.flush && wrPtr == PTR_W'(g)) begin
        store[g] <= pushData;
      end
    end
  end

  assign headByte = decodeChar(store[rdPtr], invert);

endmodule

// File: rtl/sc_conv_ctrl.sv
module sc_conv_ctrl
  import sc_conv_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1),
  parameter logic [7:0] TS_DIRECT_RAW  = 8'h3B,
  parameter logic [7:0] TS_INVERSE_RAW = 8'h03
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              rxOff,
  input  logic              autoEn,
  input  logic              convWr,
  input  logic [1:0]        convSel,
  input  logic [1:0]        trigSel,
  input  logic              rdaIntEn,
  input  logic              acErrIntEn,
  input  logic              rawValid,
  input  logic [CHAR_W-1:0] rawByte,
  input  logic              popReq,
  input  logic [CNT_W-1:0]  count,
  output bufCtl_t           ctl,
  output conv_e             conv,
  output logic              rdaFlag,
  output logic              rdaIrq,
  output logic              acErrFlag,
  output logic              acErrIrq,
  output logic              ovf
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic tsDone;
  logic accept, full, doPop, tsCheck;
  logic [CNT_W-1:0] level;

  assign full    = (count == FULL_CNT);
  assign accept  = enable && rawValid && (autoEn || !rxOff);
  assign doPop   = enable && popReq && (count != '0);
  assign tsCheck = accept && autoEn && !tsDone;

  always_comb begin
    ctl       = '0;
    ctl.flush = !enable;
    ctl.pop   = doPop;
    ctl.push  = accept && (!full || doPop);
  end

  always_comb begin
    case (trigSel)
      2'b01:   level = CNT_W'(2);
      2'b10:   level = CNT_W'(3);
      default: level = CNT_W'(1);
    endcase
  end

  assign rdaFlag  = (count >= level);
  assign rdaIrq   = rdaFlag && rdaIntEn;
  assign acErrIrq = acErrFlag && acErrIntEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tsDone <= 1'b0;
    end else if (!enable || !autoEn) begin
      tsDone <= 1'b0;
    end else if (tsCheck) begin
      tsDone <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      conv <= CONV_DIRECT;
    end else if (tsCheck) begin
      if (rawByte == TS_DIRECT_RAW)       conv <= CONV_DIRECT;
      else if (rawByte == TS_INVERSE_RAW) conv <= CONV_INVERSE;
    end else if (convWr && !autoEn) begin
      if (convSel == CONV_DIRECT || convSel == CONV_INVERSE) conv <= conv_e'(convSel);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acErrFlag <= 1'b0;
      ovf       <= 1'b0;
    end else if (!enable) begin
      acErrFlag <= 1'b0;
      ovf       <= 1'b0;
    end else begin
      if (tsCheck && rawByte != TS_DIRECT_RAW && rawByte != TS_INVERSE_RAW) acErrFlag <= 1'b1;
      if (accept && full && !doPop) ovf <= 1'b1;
    end
  end

endmodule

// File: rtl/sc_conv_detect.sv
module sc_conv_detect
  import sc_conv_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             rxOff,
  input  logic             autoEn,
  input  logic             convWr,
  input  logic [1:0]       convSel,
  input  logic [1:0]       trigSel,
  input  logic             rdaIntEn,
  input  logic             acErrIntEn,
  input  logic             rawValid,
  input  logic [7:0]       rawByte,
  input  logic             popReq,
  output logic [7:0]       outByte,
  output logic             outValid,
  output logic [CNT_W-1:0] bufCount,
  output logic [1:0]       convCur,
  output logic             rdaFlag,
  output logic             rdaIrq,
  output logic             acErr,
  output logic             acErrIrq,
  output logic             ovfFlag
);

  bufCtl_t bufCtl;
  conv_e   conv;

  sc_conv_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .rxOff      (rxOff),
    .autoEn     (autoEn),
    .convWr     (convWr),
    .convSel    (convSel),
    .trigSel    (trigSel),
    .rdaIntEn   (rdaIntEn),
    .acErrIntEn (acErrIntEn),
    .rawValid   (rawValid),
    .rawByte    (rawByte),
    .popReq     (popReq),
    .count      (bufCount),
    .ctl        (bufCtl),
    .conv       (conv),
    .rdaFlag    (rdaFlag),
    .rdaIrq     (rdaIrq),
    .acErrFlag  (acErr),
    .acErrIrq   (acErrIrq),
    .ovf        (ovfFlag)
  );

  sc_conv_dp #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (bufCtl),
    .pushData (rawByte),
    .invert   (conv == CONV_INVERSE),
    .headByte (outByte),
    .count    (bufCount)
  );

  assign convCur  = conv;
  assign outValid = (bufCount != '0);

endmodule

// File: rtl/sc_conv_detect_chk.sv
module sc_conv_detect_chk #(
  parameter int DEPTH = 4,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             rxOff,
  input logic             autoEn,
  input logic             rawValid,
  input logic             popReq,
  input logic [CNT_W-1:0] bufCount,
  input logic [1:0]       convCur,
  input logic             rdaFlag,
  input logic             acErr,
  input logic             ovfFlag
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic takeIn;
  assign takeIn = enable && rawValid && (autoEn || !rxOff);

  // R1
  conv_legal_chk: assert property (@(posedge clk) disable iff (!rstN)
    convCur == 2'b00 || convCur == 2'b11);

  // R2
  auto_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (autoEn && !rawValid) |=> $stable(convCur));

  // R5
  acerr_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(acErr) |-> $past(rawValid && autoEn && enable));

  // R7
  rda_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bufCount == '0) |-> !rdaFlag);

  // R8
  overflow_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeIn && bufCount == FULL_CNT && !popReq) |=> (ovfFlag && bufCount == FULL_CNT));

  // R9
  full_swap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (takeIn && bufCount == FULL_CNT && popReq && !ovfFlag) |=> (!ovfFlag && bufCount == FULL_CNT));

  // R11
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (bufCount == '0 && !acErr && !ovfFlag));

endmodule

bind sc_conv_detect sc_conv_detect_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .enable   (enable),
  .rxOff    (rxOff),
  .autoEn   (autoEn),
  .rawValid (rawValid),
  .popReq   (popReq),
  .bufCount (bufCount),
  .convCur  (convCur),
  .rdaFlag  (rdaFlag),
  .acErr    (acErr),
  .ovfFlag  (ovfFlag)
);

// File: tb/sc_conv_detect_tb_top.sv
`timescale 1ns/1ps
module sc_conv_detect_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0, rxOff = 1'b0, autoEn = 1'b0, convWr = 1'b0;
  logic [1:0] convSel = 2'b00, trigSel = 2'b00;
  logic rdaIntEn = 1'b0, acErrIntEn = 1'b0, rawValid = 1'b0, popReq = 1'b0;
  logic [7:0] rawByte = 8'h00;
  logic [7:0] outByte;
  logic outValid, rdaFlag, rdaIrq, acErr, acErrIrq, ovfFlag;
  logic [2:0] bufCount;
  logic [1:0] convCur;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sc_conv_detect dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .rxOff(rxOff), .autoEn(autoEn),
    .convWr(convWr), .convSel(convSel), .trigSel(trigSel), .rdaIntEn(rdaIntEn),
    .acErrIntEn(acErrIntEn), .rawValid(rawValid), .rawByte(rawByte), .popReq(popReq),
    .outByte(outByte), .outValid(outValid), .bufCount(bufCount), .convCur(convCur),
    .rdaFlag(rdaFlag), .rdaIrq(rdaIrq), .acErr(acErr), .acErrIrq(acErrIrq),
    .ovfFlag(ovfFlag)
  );

  function automatic logic [7:0] invOf(input logic [7:0] r);
    logic [7:0] o;
    for (int i = 0; i < 8; i++) o[i] = ~r[7 - i];
    return o;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendRaw(input logic [7:0] b);
    @(negedge clk); rawValid = 1'b1; rawByte = b;
    @(negedge clk); rawValid = 1'b0;
  endtask

  task automatic popOne();
    @(negedge clk); popReq = 1'b1;
    @(negedge clk); popReq = 1'b0;
  endtask

  task automatic writeConv(input logic [1:0] v);
    @(negedge clk); convWr = 1'b1; convSel = v;
    @(negedge clk); convWr = 1'b0;
  endtask

  task automatic goIdle();
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
  endtask

  task automatic testReset();
    chk("R12 conv", convCur, 0);
    chk("R12 count", bufCount, 0);
    chk("R12 outValid", outValid, 0);
    chk("R12 flags", {rdaFlag, rdaIrq, acErr, acErrIrq, ovfFlag}, 0);
  endtask

  task automatic testManual();
    autoEn = 1'b0; enable = 1'b1;
    writeConv(2'b11);
    chk("R1 set inverse", convCur, 3);
    writeConv(2'b01);
    chk("R1 reserved 01 ignored", convCur, 3);
    writeConv(2'b10);
    chk("R1 reserved 10 ignored", convCur, 3);
    sendRaw(8'hA6);
    chk("R1 inverse decode", outByte, invOf(8'hA6));
    writeConv(2'b00);
    chk("R1 direct redecode", outByte, 8'hA6);
    goIdle();
  endtask

  task automatic testAutoDirect();
    writeConv(2'b11);
    @(negedge clk); enable = 1'b0; autoEn = 1'b1;
    @(negedge clk); enable = 1'b1;
    sendRaw(8'h3B);
    chk("R3 conv direct", convCur, 0);
    chk("R3 stored TS", outByte, 8'h3B);
    writeConv(2'b11);
    chk("R2 write ignored", convCur, 0);
    sendRaw(8'h03);
    chk("R6 second char not classified", convCur, 0);
    chk("R6 count", bufCount, 2);
  endtask

  task automatic testAutoInverse();
    goIdle();
    sendRaw(8'h03);
    chk("R4 conv inverse", convCur, 3);
    chk("R4 stored TS", outByte, 8'h3F);
    chk("R4 no error", acErr, 0);
    popOne();
    sendRaw(8'h5C);
    chk("R4 later char", outByte, invOf(8'h5C));
  endtask

  task automatic testAutoError();
    goIdle();
    acErrIntEn = 1'b0;
    sendRaw(8'h55);
    chk("R5 acErr set", acErr, 1);
    chk("R5 irq masked", acErrIrq, 0);
    chk("R5 conv kept", convCur, 3);
    chk("R5 char stored", bufCount, 1);
    acErrIntEn = 1'b1; #1;
    chk("R5 irq enabled", acErrIrq, 1);
    sendRaw(8'h3B);
    chk("R6 no reclassify", convCur, 3);
    acErrIntEn = 1'b0;
  endtask

  task automatic testTrigger();
    @(negedge clk); autoEn = 1'b0;
    goIdle();
    writeConv(2'b00);
    trigSel = 2'b01; rdaIntEn = 1'b0;
    sendRaw(8'h11);
    chk("R7 below level 2", rdaFlag, 0);
    sendRaw(8'h22);
    chk("R7 at level 2", rdaFlag, 1);
    chk("R7 irq masked", rdaIrq, 0);
    rdaIntEn = 1'b1; #1;
    chk("R7 irq enabled", rdaIrq, 1);
    trigSel = 2'b10; #1;
    chk("R7 level 3 not reached", rdaFlag, 0);
    trigSel = 2'b11; #1;
    chk("R7 reserved means 1", rdaFlag, 1);
    trigSel = 2'b00; rdaIntEn = 1'b0;
  endtask

  task automatic testOverflow();
    goIdle();
    for (int i = 0; i < 4; i++) sendRaw(8'h40 + 8'(i));
    chk("R8 full", bufCount, 4);
    chk("R8 no ovf yet", ovfFlag, 0);
    sendRaw(8'h99);
    chk("R8 ovf set", ovfFlag, 1);
    chk("R8 count stays", bufCount, 4);
    for (int i = 0; i < 4; i++) begin
      chk("R8 order", outByte, 8'h40 + i);
      popOne();
    end
    chk("R8 dropped byte absent", bufCount, 0);
    chk("R8 ovf sticky", ovfFlag, 1);
  endtask

  task automatic testSameCycle();
    goIdle();
    for (int i = 0; i < 4; i++) sendRaw(8'h60 + 8'(i));
    @(negedge clk); rawValid = 1'b1; rawByte = 8'h77; popReq = 1'b1;
    @(negedge clk); rawValid = 1'b0; popReq = 1'b0;
    chk("R9 count", bufCount, 4);
    chk("R9 no ovf", ovfFlag, 0);
    chk("R9 head advanced", outByte, 8'h61);
    for (int i = 0; i < 3; i++) popOne();
    chk("R9 new byte at tail", outByte, 8'h77);
  endtask

  task automatic testRxOff();
    goIdle();
    rxOff = 1'b1;
    sendRaw(8'h12);
    chk("R10 blocked", bufCount, 0);
    @(negedge clk); enable = 1'b0; autoEn = 1'b1;
    writeConv(2'b11);
    @(negedge clk); enable = 1'b1;
    sendRaw(8'h3B);
    chk("R10 ignored in auto", bufCount, 1);
    chk("R10 classified", convCur, 0);
    rxOff = 1'b0;
  endtask

  task automatic testIdle();
    sendRaw(8'h20);
    for (int i = 0; i < 3; i++) sendRaw(8'h21);
    chk("R11 ovf before idle", ovfFlag, 1);
    @(negedge clk); enable = 1'b0;
    @(negedge clk);
    chk("R11 flushed", bufCount, 0);
    chk("R11 ovf cleared", ovfFlag, 0);
    sendRaw(8'h44);
    chk("R11 input ignored", bufCount, 0);
    chk("R11 conv kept", convCur, 0);
    @(negedge clk); enable = 1'b1;
    sendRaw(8'h03);
    chk("R11 rearmed", convCur, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testManual();
    testAutoDirect();
    testAutoInverse();
    testAutoError();
    testTrigger();
    testOverflow();
    testSameCycle();
    testRxOff();
    testIdle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule